// File: doc/BRIEF.md
# Redundant Bus State Controller

This block holds the four-flag bus state code of one memory-system node that may own a redundant back-up bus. From the code it derives two steering signals: which physical bus the node drives (normal or back-up), and whether memory traffic may be placed on a bus at all. In the null state memory traffic is blocked, while interconnect traffic remains allowed.

The code is loaded by an initialisation strobe from a strap that tells whether a back-up bus is fitted. After that it is changed only by three command strobes (attach, detach, interchange) and by a permanent-bus-error indication that carries a flag naming the failed bus. Each change passes through a short fixed pipeline. A command is acknowledged first. The code changes one cycle later, and one cycle after that a single-cycle report event names what happened. Automatic switching on a permanent bus error can be turned off with a recovery-disable input. The explicit interchange command keeps working when it is off.

Top module: `bus_state_ctrl`

## Requirements
- R1: After reset `state_code` is 0000, and `use_backup`, `mem_enable`, `cmd_ack` and `report_valid` are 0. `state_code` only ever holds one of the seven legal codes 0000, 0001, 0100, 0101, 1010, 1100 and 0011 (written bit 3 down to bit 0). Bit 0 is the node's own normal enable, bit 1 its own back-up enable, bit 2 the partner's normal enable and bit 3 the partner's back-up enable.
- R2: An `init_strobe` sampled at a clock edge loads the code at that edge. The new code is 0101 when `redundant_strap` is 1 and 0000 when it is 0. Init overrides every other input, cancels any pending acknowledge or report, and does not itself acknowledge or report.
- R3: `use_backup` is 1 exactly when the code is 0100, 1010 or 1100.
- R4: `mem_enable` is 0 exactly when the code is 0000.
- R5: A command strobe (`cmd_attach`, `cmd_detach`, `cmd_interchange`) that is accepted at edge E raises `cmd_ack` for the one cycle after E. The code is unchanged during that cycle. Any new code appears from edge E+1. A permanent-error event is never acknowledged.
- R6: When an accepted event changes the code at edge E+1, `report_valid` is 1 for exactly the one cycle after edge E+2. `report_type` is then 1 for attach, 2 for detach, 3 for interchange and 4 for a permanent-bus-error switch. It is 0 whenever `report_valid` is 0.
- R7: Interchange moves 0101 to 1010 and 1010 to 0101. In any other code it has no effect.
- R8: Attach moves 1100 to 0101 and has no effect in any other code. Detach moves 0101 to 1100 and 0011 to 0000, and has no effect in any other code.
- R9: A permanent bus error with `err_on_backup`=0 (normal bus failed) moves 0101 to 1100 and 0011 to 0000. With `err_on_backup`=1 it moves 0101 to 0011 and 1100 to 0000. In other codes it has no effect.
- R10: When `recovery_dis` is 1 at the edge where a permanent error is sampled, the code stays the same and no report is emitted. Interchange still works while `recovery_dis` is 1.
- R11: A command that has no effect in the current code is still acknowledged. It leaves the code unchanged and emits no report.
- R12: When several strobes are sampled at once, the priority is init, then permanent error, then interchange, then detach, then attach. Only the winner is accepted. Strobes sampled at the two edges that follow an accepted event are ignored: they produce no acknowledge, no change and no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_strobe | input | 1 | Load the code from the strap |
| redundant_strap | input | 1 | 1 when a back-up bus is fitted |
| cmd_attach | input | 1 | Attach command strobe |
| cmd_detach | input | 1 | Detach command strobe |
| cmd_interchange | input | 1 | Bus-interchange command strobe |
| perm_bus_err | input | 1 | Permanent bus error indication |
| err_on_backup | input | 1 | 1 when the failed bus is the back-up bus |
| recovery_dis | input | 1 | Suppress automatic switching on bus errors |
| state_code | output | 4 | Current bus state code |
| use_backup | output | 1 | Node drives its back-up bus |
| mem_enable | output | 1 | Memory accesses may use the bus |
| cmd_ack | output | 1 | One-cycle command acknowledge |
| report_valid | output | 1 | One-cycle report event |
| report_type | output | 3 | Report kind while `report_valid` is 1 |

## Verification
A wrong stored code shows at `state_code` one cycle after the edge that should have applied the change. It shows on `use_backup` and `mem_enable` in the same cycle, because both are decoded directly from the stored code. A pipeline fault shows as an acknowledge, or as the code change, landing one cycle early or late. It can also show as a report that fires for a command with no effect, or as a second event slipping in during the two-edge busy window. These faults appear within three cycles of the strobe. Priority and recovery-disable faults show in the next code after a collision or a suppressed error.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int CODE_W = 4;
  localparam int TYPE_W = 3;

  localparam logic [CODE_W-1:0] C_NULL    = 4'b0000;
  localparam logic [CODE_W-1:0] C_NORM_UP = 4'b0001;
  localparam logic [CODE_W-1:0] C_BACK_UP = 4'b0100;
  localparam logic [CODE_W-1:0] C_QUAD    = 4'b0101;
  localparam logic [CODE_W-1:0] C_SWAP    = 4'b1010;
  localparam logic [CODE_W-1:0] C_NDOWN   = 4'b1100;
  localparam logic [CODE_W-1:0] C_BDOWN   = 4'b0011;

  // event kind; the value doubles as the report type
  typedef enum logic [TYPE_W-1:0] {
    OP_NONE   = 3'd0,
    OP_ATTACH = 3'd1,
    OP_DETACH = 3'd2,
    OP_XCHG   = 3'd3,
    OP_FAULT  = 3'd4
  } bsc_op_e;

  typedef struct packed {
    logic              chg;
    logic [CODE_W-1:0] code;
  } bsc_step_t;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return (c == C_NULL) || (c == C_NORM_UP) || (c == C_BACK_UP) ||
           (c == C_QUAD) || (c == C_SWAP) || (c == C_NDOWN) || (c == C_BDOWN);
  endfunction

  function automatic logic on_backup(input logic [CODE_W-1:0] c);
    return (c == C_BACK_UP) || (c == C_SWAP) || (c == C_NDOWN);
  endfunction

  function automatic logic mem_allowed(input logic [CODE_W-1:0] c);
    return c != C_NULL;
  endfunction

  function automatic logic [CODE_W-1:0] init_code(input logic strap);
    return {1'b0, strap, 1'b0, strap};
  endfunction

  function automatic bsc_step_t bsc_next(input logic [CODE_W-1:0] c,
                                         input bsc_op_e op,
                                         input logic bk,
                                         input logic rdis);
    bsc_step_t r;
    r.code = c;
    case (op)
      OP_XCHG: begin
        if (c == C_QUAD)      r.code = C_SWAP;
        else if (c == C_SWAP) r.code = C_QUAD;
      end
      OP_ATTACH: begin
        if (c == C_NDOWN) r.code = C_QUAD;
      end
      OP_DETACH: begin
        if (c == C_QUAD)       r.code = C_NDOWN;
        else if (c == C_BDOWN) r.code = C_NULL;
      end
      OP_FAULT: begin
        if (!rdis) begin
          if (!bk) begin
            if (c == C_QUAD)       r.code = C_NDOWN;
            else if (c == C_BDOWN) r.code = C_NULL;
          end else begin
            if (c == C_QUAD)       r.code = C_BDOWN;
            else if (c == C_NDOWN) r.code = C_NULL;
          end
        end
      end
      default: r.code = c;
    endcase
    r.chg = (r.code != c);
    return r;
  endfunction
endpackage

// File: rtl/bsc_arbiter.sv
module bsc_arbiter
  import bsc_pkg::*;
(
  input  logic    cmd_attach,
  input  logic    cmd_detach,
  input  logic    cmd_interchange,
  input  logic    perm_bus_err,
  output bsc_op_e req_op
);
  always_comb begin
    if (perm_bus_err)         req_op = OP_FAULT;
    else if (cmd_interchange) req_op = OP_XCHG;
    else if (cmd_detach)      req_op = OP_DETACH;
    else if (cmd_attach)      req_op = OP_ATTACH;
    else                      req_op = OP_NONE;
  end
endmodule

// File: rtl/bsc_transition.sv
module bsc_transition
  import bsc_pkg::*;
(
  input  logic [CODE_W-1:0] cur_code,
  input  bsc_op_e           op,
  input  logic              bk,
  input  logic              rdis,
  output bsc_step_t         step
);
  always_comb step = bsc_next(cur_code, op, bk, rdis);
endmodule

// File: rtl/bsc_sequencer.sv
module bsc_sequencer
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_strobe,
  input  logic [CODE_W-1:0] init_val,
  input  bsc_op_e           req_op,
  input  logic              req_bk,
  input  logic              req_rdis,
  input  bsc_step_t         step,
  output logic [CODE_W-1:0] cur_code,
  output bsc_op_e           s1_op,
  output logic              s1_bk,
  output logic              s1_rdis,
  output logic              ack,
  output logic              rep_v,
  output bsc_op_e           rep_t,
  output logic              ev_accept,
  output logic              ev_apply
);
  logic    s1_vld;
  logic    s2_vld;
  logic    s2_chg;
  bsc_op_e s2_op;

  assign ev_accept = !s1_vld && !s2_vld && (req_op != OP_NONE) && !init_strobe;
  assign ev_apply  = s1_vld && step.chg && !init_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= C_NULL;
      s1_vld   <= 1'b0;
      s1_op    <= OP_NONE;
      s1_bk    <= 1'b0;
      s1_rdis  <= 1'b0;
      s2_vld   <= 1'b0;
      s2_chg   <= 1'b0;
      s2_op    <= OP_NONE;
      ack      <= 1'b0;
      rep_v    <= 1'b0;
      rep_t    <= OP_NONE;
    end else if (init_strobe) begin
      cur_code <= init_val;
      s1_vld   <= 1'b0;
      s2_vld   <= 1'b0;
      ack      <= 1'b0;
      rep_v    <= 1'b0;
      rep_t    <= OP_NONE;
    end else begin
      ack    <= ev_accept && (req_op != OP_FAULT);
      s1_vld <= ev_accept;
      if (ev_accept) begin
        s1_op   <= req_op;
        s1_bk   <= req_bk;
        s1_rdis <= req_rdis;
      end
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_chg <= step.chg;
        s2_op  <= s1_op;
        if (step.chg) cur_code <= step.code;
      end
      rep_v <= s2_vld && s2_chg;
      rep_t <= (s2_vld && s2_chg) ? s2_op : OP_NONE;
    end
  end
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
(
  input  logic [CODE_W-1:0] cur_code,
  output logic              use_backup,
  output logic              mem_enable
);
  assign use_backup = on_backup(cur_code);
  assign mem_enable = mem_allowed(cur_code);
endmodule

// File: rtl/bus_state_ctrl.sv
module bus_state_ctrl
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_strobe,
  input  logic              redundant_strap,
  input  logic              cmd_attach,
  input  logic              cmd_detach,
  input  logic              cmd_interchange,
  input  logic              perm_bus_err,
  input  logic              err_on_backup,
  input  logic              recovery_dis,
  output logic [CODE_W-1:0] state_code,
  output logic              use_backup,
  output logic              mem_enable,
  output logic              cmd_ack,
  output logic              report_valid,
  output logic [TYPE_W-1:0] report_type
);
  bsc_op_e           req_op;
  bsc_op_e           s1_op;
  bsc_op_e           rep_t;
  logic              s1_bk;
  logic              s1_rdis;
  bsc_step_t         step;
  logic              ev_accept;
  logic              ev_apply;
  logic [CODE_W-1:0] init_val;

  assign init_val = init_code(redundant_strap);

  bsc_arbiter u_arb (
    .cmd_attach      (cmd_attach),
    .cmd_detach      (cmd_detach),
    .cmd_interchange (cmd_interchange),
    .perm_bus_err    (perm_bus_err),
    .req_op          (req_op)
  );

  bsc_transition u_trn (
    .cur_code (state_code),
    .op       (s1_op),
    .bk       (s1_bk),
    .rdis     (s1_rdis),
    .step     (step)
  );

  bsc_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_strobe (init_strobe),
    .init_val    (init_val),
    .req_op      (req_op),
    .req_bk      (err_on_backup),
    .req_rdis    (recovery_dis),
    .step        (step),
    .cur_code    (state_code),
    .s1_op       (s1_op),
    .s1_bk       (s1_bk),
    .s1_rdis     (s1_rdis),
    .ack         (cmd_ack),
    .rep_v       (report_valid),
    .rep_t       (rep_t),
    .ev_accept   (ev_accept),
    .ev_apply    (ev_apply)
  );

  assign report_type = rep_t;

  bsc_decode u_dec (
    .cur_code   (state_code),
    .use_backup (use_backup),
    .mem_enable (mem_enable)
  );
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
  import bsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              init_strobe,
  input logic [CODE_W-1:0] state_code,
  input logic              cmd_ack,
  input logic              report_valid,
  input logic [TYPE_W-1:0] report_type,
  input logic              ev_accept,
  input logic              ev_apply
);
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(state_code));

  assert_ack_before_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $stable(state_code));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack);

  assert_report_after_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid |-> $past(ev_apply, 2));

  assert_report_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid |=> !report_valid);

  assert_report_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    report_valid |-> (report_type >= 3'd1 && report_type <= 3'd4));

  assert_busy_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !init_strobe) |=> !ev_accept);

  assert_ack_report_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack && report_valid));
endmodule

bind bus_state_ctrl bsc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_strobe  (init_strobe),
  .state_code   (state_code),
  .cmd_ack      (cmd_ack),
  .report_valid (report_valid),
  .report_type  (report_type),
  .ev_accept    (ev_accept),
  .ev_apply     (ev_apply)
);

// File: tb/tb_bus_state_ctrl.sv
`timescale 1ns/1ps
module tb_bus_state_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_strobe = 0, redundant_strap = 0;
  logic       cmd_attach = 0, cmd_detach = 0, cmd_interchange = 0;
  logic       perm_bus_err = 0, err_on_backup = 0, recovery_dis = 0;
  logic [3:0] state_code;
  logic       use_backup, mem_enable, cmd_ack, report_valid;
  logic [2:0] report_type;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // model state: index 0..6 per the legal code list
  int m_idx = 0, m_phase = 0, m_pidx = 0, m_pop = 0;
  bit m_pchg = 0, m_ack = 0, m_rv = 0;
  int m_rt = 0;

  always #2.5 clk = ~clk;

  bus_state_ctrl dut (.*);

  function automatic logic [3:0] idx2code(int i);
    case (i)
      1: return 4'b0001;
      2: return 4'b0100;
      3: return 4'b0101;
      4: return 4'b1010;
      5: return 4'b1100;
      6: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  // op: 1 attach, 2 detach, 3 interchange, 4 fault
  function automatic int exp_step(int i, int op, bit bk, bit rdis);
    if (op == 3) return (i == 3) ? 4 : (i == 4) ? 3 : i;
    if (op == 1) return (i == 5) ? 3 : i;
    if (op == 2) return (i == 3) ? 5 : (i == 6) ? 0 : i;
    if (op == 4 && !rdis) begin
      if (!bk) return (i == 3) ? 5 : (i == 6) ? 0 : i;
      return (i == 3) ? 6 : (i == 5) ? 0 : i;
    end
    return i;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "state_code", state_code, idx2code(m_idx));
    chk("R3", "use_backup", use_backup, (m_idx == 2 || m_idx == 4 || m_idx == 5));
    chk("R4", "mem_enable", mem_enable, (m_idx != 0));
    chk("R5", "cmd_ack", cmd_ack, m_ack);
    chk("R6", "report_valid", report_valid, m_rv);
    chk("R6", "report_type", report_type, m_rt);
  endtask

  task automatic model_update();
    int op;
    bit nrv;
    int nrt;
    if (init_strobe) begin
      m_idx = redundant_strap ? 3 : 0;
      m_phase = 0; m_ack = 0; m_rv = 0; m_rt = 0;
    end else begin
      nrv = (m_phase == 2) && m_pchg;
      nrt = nrv ? m_pop : 0;
      m_ack = 0;
      if (m_phase == 1) begin
        if (m_pchg) m_idx = m_pidx;
        m_phase = 2;
      end else if (m_phase == 2) begin
        m_phase = 0;
      end else begin
        op = perm_bus_err ? 4 : cmd_interchange ? 3 : cmd_detach ? 2 : cmd_attach ? 1 : 0;
        if (op != 0) begin
          m_pidx = exp_step(m_idx, op, err_on_backup, recovery_dis);
          m_pchg = (m_pidx != m_idx);
          m_pop = op;
          m_ack = (op != 4);
          m_phase = 1;
        end
      end
      m_rv = nrv; m_rt = nrt;
    end
  endtask

  task automatic cyc(bit ini, bit strap, bit att, bit det, bit xch, bit err, bit bk, bit rdis);
    @(negedge clk);
    compare_all();
    init_strobe = ini; redundant_strap = strap;
    cmd_attach = att; cmd_detach = det; cmd_interchange = xch;
    perm_bus_err = err; err_on_backup = bk; recovery_dis = rdis;
    model_update();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset state_code", state_code, 0);
    chk("R1", "reset use_backup", use_backup, 0);
    chk("R1", "reset mem_enable", mem_enable, 0);
    chk("R1", "reset cmd_ack", cmd_ack, 0);
    chk("R1", "reset report_valid", report_valid, 0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";  cyc(1, 1, 0, 0, 0, 0, 0, 0); idle(3);
    cur_req = "R7";  cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(4);
                     cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(4);
    cur_req = "R9";  cyc(0, 0, 0, 0, 0, 1, 0, 0); idle(4);
    cur_req = "R8";  cyc(0, 0, 1, 0, 0, 0, 0, 0); idle(4);
                     cyc(0, 0, 0, 1, 0, 0, 0, 0); idle(4);
                     cyc(0, 0, 1, 0, 0, 0, 0, 0); idle(4);
    cur_req = "R9";  cyc(0, 0, 0, 0, 0, 1, 1, 0); idle(4);
    cur_req = "R8";  cyc(0, 0, 0, 1, 0, 0, 0, 0); idle(4);
    cur_req = "R11"; cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(4);
    cur_req = "R2";  cyc(1, 1, 0, 0, 0, 0, 0, 0); idle(2);
    cur_req = "R10"; cyc(0, 0, 0, 0, 0, 1, 0, 1); idle(4);
                     cyc(0, 0, 0, 0, 1, 0, 0, 1); idle(4);
    cur_req = "R11"; cyc(0, 0, 1, 0, 0, 0, 0, 0); idle(4);
                     cyc(0, 0, 0, 1, 0, 0, 0, 0); idle(4);
    cur_req = "R12"; cyc(0, 0, 0, 0, 1, 0, 0, 0); idle(4);
                     cyc(0, 0, 1, 1, 1, 1, 0, 0); idle(4);
                     cyc(0, 0, 1, 0, 0, 0, 0, 0);
                     cyc(0, 0, 0, 1, 0, 0, 0, 0);
                     cyc(0, 0, 0, 1, 0, 0, 0, 0); idle(4);
    cur_req = "R2";  cyc(1, 0, 0, 0, 0, 0, 0, 0); idle(1);
                     cyc(1, 1, 0, 0, 0, 0, 0, 0);
                     cyc(0, 0, 0, 0, 1, 0, 0, 0);
                     cyc(1, 1, 0, 0, 0, 0, 0, 0); idle(4);

    // R12 random mix with fixed seed
    cur_req = "R12";
    void'($urandom(32'h5eed_0b5c));
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 64) == 0, $urandom % 2,
          ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
          ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0);
    end
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule